// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits next to a small 32-bit processor core and performs the hardware side of exception entry. The core presents its pending exception sources as a flat request vector, along with the TRAP number, the autovector interrupt level, an externally supplied interrupt vector, the PC of the offending instruction, the PC of the following instruction, the status register and the current stack pointer. The block picks the most urgent source, turns it into a vector number, and decides which PC belongs in the frame. It then writes a two-longword frame below the stack pointer through a handshaked memory port and reads the handler address from the vector table.

Once the handler address is known, the block gives the core a one-cycle redirect with the handler address and the new stack pointer. Interrupt-class sources are then held off until the core reports that the handler's first instruction has retired. The handler can therefore raise its interrupt mask before any interrupt is taken. A fault-class source that appears in that window can still start a nested entry.

Top module: `exc_entry_seq`

## Requirements
- R1: Request bits are ranked by position, and the lowest set bit wins. The bits are: 0 access error, 1 address error, 2 illegal opcode, 3 privilege violation, 4 line-A opcode, 5 line-F opcode, 6 unsupported instruction, 7 divide by zero, 8 format error, 9 TRAP, 10 trace, 11 PC breakpoint, 12 non-PC breakpoint, 13 uninitialized interrupt, 14 spurious interrupt, 15 autovectored interrupt, 16 externally vectored interrupt.
- R2: Each bit maps to a vector number:
  - bits 0 to 8 map to 2, 3, 4, 8, 10, 11, 61, 5 and 14 in turn;
  - TRAP maps to 32 plus the 4-bit TRAP number;
  - trace maps to 9, and the PC and non-PC breakpoints map to 13 and 12;
  - the uninitialized and spurious interrupts map to 15 and 24;
  - an autovectored interrupt at level L maps to 24+L;
  - an externally vectored interrupt uses its supplied 8-bit vector.
- R3: An autovectored interrupt with level 0, or an external vector below 64, is handled as a format error (vector 14). Vectors 0, 1, 6–7, 16–23, 48–60 and 62–63 are never produced.
- R4: The frame holds the faulting PC for vectors 2, 3, 4, 5, 8, 10, 11, 14 and 61, and the next PC for every other vector.
- R5: The first write goes to SP−4 with the saved PC. The second write goes to SP−8 with {format code 6'b010000, vector, 2'b00} in bits 31:16 and the status register in bits 15:0.
- R6: A memory request holds its address, write data and write enable unchanged until it is acknowledged, however many cycles that takes.
- R7: After the two writes, the block reads address table_base + vector×4. One cycle after that read is acknowledged, it raises the redirect strobe for exactly one cycle, with the read data as the handler address and SP−8 as the new stack pointer.
- R8: The interrupt-inhibit output is high from acceptance until the first-retired input is seen after the redirect. While it is high, interrupt-class sources (bits 10 to 16) start no sequence.
- R9: While the block waits for the handler's first instruction to retire, a fault-class source (bits 0 to 9) starts a new nested entry.
- R10: After reset, the block issues no memory request, no redirect, and holds the interrupt-inhibit output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | 17 | Pending exception sources, one bit per source |
| trap_num | input | 4 | TRAP instruction number |
| irq_level | input | 3 | Autovectored interrupt level |
| irq_vec | input | 8 | Externally supplied interrupt vector |
| fault_pc | input | 32 | PC of the offending instruction |
| next_pc | input | 32 | PC of the following instruction |
| sr | input | 16 | Status register |
| sp | input | 32 | Current stack pointer |
| tbl_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data |
| redirect_valid | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Handler address |
| redirect_sp | output | 32 | Stack pointer after the frame |
| irq_inhibit | output | 1 | Interrupt sampling blocked |
| first_retired | input | 1 | Handler's first instruction has retired |

## Verification
The bench raises several sources at once:
- An access error together with an interrupt: a wrong ranking would stack the interrupt vector and the next PC.
- Trace together with an external interrupt: the same kind of error would show up here.

It also sends invalid interrupt encodings. A design that lets these through would fetch from a reserved or user table slot instead of vector 14.

An interrupt is raised while the handler's first instruction is outstanding. A design that samples it early would open a memory request in that window. A fault raised in the same window must produce a second frame, and a design that blocks all sources there would hang.

Slow acknowledges are used throughout. A design that advances or changes its address before the acknowledge would make the scoreboard see frame words out of place.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NSRC      = 17;
  localparam int IDX_W     = $clog2(NSRC);
  localparam int NEST_LAST = 9;

  localparam int SRC_ACCESS = 0;
  localparam int SRC_ADDR   = 1;
  localparam int SRC_ILLEG  = 2;
  localparam int SRC_PRIV   = 3;
  localparam int SRC_LINEA  = 4;
  localparam int SRC_LINEF  = 5;
  localparam int SRC_UNSUP  = 6;
  localparam int SRC_DIVZ   = 7;
  localparam int SRC_FMT    = 8;
  localparam int SRC_TRAP   = 9;
  localparam int SRC_TRACE  = 10;
  localparam int SRC_BKPC   = 11;
  localparam int SRC_BKNPC  = 12;
  localparam int SRC_UNINIT = 13;
  localparam int SRC_SPUR   = 14;
  localparam int SRC_AUTO   = 15;
  localparam int SRC_USER   = 16;

  localparam logic [7:0] VEC_FORMAT = 8'd14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_PC, ST_PUSH_FV, ST_FETCH, ST_JUMP, ST_HOLD
  } seq_state_e;

  function automatic logic [7:0] src_vector(input logic [IDX_W-1:0] idx,
                                            input logic [3:0] trap,
                                            input logic [2:0] lvl,
                                            input logic [7:0] uvec);
    logic [7:0] v;
    case (int'(idx))
      SRC_ACCESS: v = 8'd2;
      SRC_ADDR:   v = 8'd3;
      SRC_ILLEG:  v = 8'd4;
      SRC_PRIV:   v = 8'd8;
      SRC_LINEA:  v = 8'd10;
      SRC_LINEF:  v = 8'd11;
      SRC_UNSUP:  v = 8'd61;
      SRC_DIVZ:   v = 8'd5;
      SRC_TRAP:   v = 8'd32 + {4'd0, trap};
      SRC_TRACE:  v = 8'd9;
      SRC_BKPC:   v = 8'd13;
      SRC_BKNPC:  v = 8'd12;
      SRC_UNINIT: v = 8'd15;
      SRC_SPUR:   v = 8'd24;
      SRC_AUTO:   v = (lvl == 3'd0) ? VEC_FORMAT : 8'd24 + {5'd0, lvl};
      SRC_USER:   v = (uvec < 8'd64) ? VEC_FORMAT : uvec;
      default:    v = VEC_FORMAT;
    endcase
    return v;
  endfunction

  function automatic logic saves_fault_pc(input logic [7:0] v);
    return v inside {8'd2, 8'd3, 8'd4, 8'd5, 8'd8, 8'd10, 8'd11, 8'd14, 8'd61};
  endfunction

  function automatic logic vec_reserved(input logic [7:0] v);
    return (v < 8'd2) ||
           (v inside {[8'd6:8'd7], [8'd16:8'd23], [8'd48:8'd60], [8'd62:8'd63]});
  endfunction

  function automatic logic [15:0] fv_word(input logic [5:0] fmt,
                                          input logic [7:0] v);
    return {fmt, v, 2'b00};
  endfunction

endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  req,
  input  logic             nest_only,
  input  logic [3:0]       trap,
  input  logic [2:0]       lvl,
  input  logic [7:0]       uvec,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output logic [7:0]       vector
);

  localparam logic [NSRC-1:0] NEST_MASK = NSRC'((1 << (NEST_LAST + 1)) - 1);

  logic [NSRC-1:0] masked;

  assign masked = nest_only ? (req & NEST_MASK) : req;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (masked[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign vector = src_vector(idx, trap, lvl, uvec);

  // R3: a chosen source never yields a reserved or reset-only vector
  p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> !vec_reserved(vector));

  // R8: while only nesting is allowed, no interrupt-class source wins
  p_irq_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (nest_only && hit) |-> (req[idx] && int'(idx) <= NEST_LAST));

endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
  import exc_seq_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter logic [5:0] FMT_CODE = 6'b010000
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      vec_in,
  input  logic [XLEN-1:0] pc_in,
  input  logic [15:0]     sr_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] base_in,
  input  logic            retire,
  output logic            accept_ok,
  output logic            in_hold,
  output logic            busy,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] redirect_sp
);

  localparam logic [XLEN-1:0] WORD_B  = XLEN'(4);
  localparam logic [XLEN-1:0] FRAME_B = XLEN'(8);

  seq_state_e      state;
  logic [7:0]      vec_q;
  logic [XLEN-1:0] pc_q, sp_q, base_q, handler_q;
  logic [15:0]     sr_q;
  logic            xfer_done;

  assign xfer_done = mem_req && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vec_q     <= '0;
      pc_q      <= '0;
      sp_q      <= '0;
      base_q    <= '0;
      sr_q      <= '0;
      handler_q <= '0;
    end else begin
      case (state)
        ST_IDLE, ST_HOLD: begin
          if (start) begin
            vec_q  <= vec_in;
            pc_q   <= pc_in;
            sr_q   <= sr_in;
            sp_q   <= sp_in;
            base_q <= base_in;
            state  <= ST_PUSH_PC;
          end else if (state == ST_HOLD && retire) begin
            state <= ST_IDLE;
          end
        end
        ST_PUSH_PC: if (xfer_done) state <= ST_PUSH_FV;
        ST_PUSH_FV: if (xfer_done) state <= ST_FETCH;
        ST_FETCH: begin
          if (xfer_done) begin
            handler_q <= mem_rdata;
            state     <= ST_JUMP;
          end
        end
        ST_JUMP: state <= ST_HOLD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      ST_PUSH_PC: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - WORD_B;
        mem_wdata = pc_q;
      end
      ST_PUSH_FV: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = sp_q - FRAME_B;
        mem_wdata = XLEN'({fv_word(FMT_CODE, vec_q), sr_q});
      end
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = base_q + XLEN'({vec_q, 2'b00});
      end
      default: ;
    endcase
  end

  assign accept_ok      = (state == ST_IDLE) || (state == ST_HOLD);
  assign in_hold        = (state == ST_HOLD);
  assign busy           = (state != ST_IDLE);
  assign redirect_valid = (state == ST_JUMP);
  assign redirect_pc    = handler_q;
  assign redirect_sp    = sp_q - FRAME_B;

  // R6: an unanswered request keeps every field steady
  p_req_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_we) && $stable(mem_wdata)));

  // R7: the redirect strobe lasts one cycle
  p_redirect_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid);

  // R7: the redirect follows an acknowledged table read
  p_redirect_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> redirect_valid);

  // R5: the second frame write directly follows the first
  p_write_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && mem_wdata == pc_q && state == ST_PUSH_PC)
      |=> (mem_req && mem_we && mem_addr == $past(mem_addr) - WORD_B));

  // R8: sampling stays blocked right after the redirect
  p_inhibit_after_jump_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> busy);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter logic [5:0] FMT_CODE = 6'b010000
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [16:0]     exc_req,
  input  logic [3:0]      trap_num,
  input  logic [2:0]      irq_level,
  input  logic [7:0]      irq_vec,
  input  logic [XLEN-1:0] fault_pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic [15:0]     sr,
  input  logic [XLEN-1:0] sp,
  input  logic [XLEN-1:0] tbl_base,
  output logic            mem_req,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] mem_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic [XLEN-1:0] redirect_sp,
  output logic            irq_inhibit,
  input  logic            first_retired
);

  logic             sel_hit;
  logic [IDX_W-1:0] sel_idx;
  logic [7:0]       sel_vec;
  logic             accept_ok, in_hold, seq_busy, start;
  logic [XLEN-1:0]  saved_pc;

  exc_prio_sel u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (exc_req),
    .nest_only (seq_busy),
    .trap      (trap_num),
    .lvl       (irq_level),
    .uvec      (irq_vec),
    .hit       (sel_hit),
    .idx       (sel_idx),
    .vector    (sel_vec)
  );

  assign start    = sel_hit && accept_ok;
  assign saved_pc = saves_fault_pc(sel_vec) ? fault_pc : next_pc;

  exc_frame_seq #(.XLEN(XLEN), .FMT_CODE(FMT_CODE)) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .vec_in         (sel_vec),
    .pc_in          (saved_pc),
    .sr_in          (sr),
    .sp_in          (sp),
    .base_in        (tbl_base),
    .retire         (first_retired),
    .accept_ok      (accept_ok),
    .in_hold        (in_hold),
    .busy           (seq_busy),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .mem_rdata      (mem_rdata),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .redirect_sp    (redirect_sp)
  );

  assign irq_inhibit = seq_busy;

  // R8: a retire with no nested fault releases interrupt sampling
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && first_retired && !start) |=> !irq_inhibit);

  // R9: a fault-class source during the hold window opens a new frame
  p_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hold && |exc_req[NEST_LAST:0]) |=> (mem_req && mem_we));

  // R10: no traffic leaves the block while it is idle and unrequested
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_inhibit && !mem_req) |-> !redirect_valid);

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [16:0] exc_req = '0;
  logic [3:0]  trap_num = '0;
  logic [2:0]  irq_level = '0;
  logic [7:0]  irq_vec = '0;
  logic [31:0] fault_pc = '0, next_pc = '0, sp = '0, tbl_base = 32'h0001_0000;
  logic [15:0] sr = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        redirect_valid, irq_inhibit, first_retired = 1'b0;
  logic [31:0] redirect_pc, redirect_sp;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .trap_num(trap_num),
    .irq_level(irq_level), .irq_vec(irq_vec), .fault_pc(fault_pc),
    .next_pc(next_pc), .sr(sr), .sp(sp), .tbl_base(tbl_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .redirect_sp(redirect_sp), .irq_inhibit(irq_inhibit),
    .first_retired(first_retired)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          kind;   // 0 write, 1 read, 2 redirect
    logic [31:0] addr;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int   checks = 0, errors = 0, wait_cfg = 0, wcnt = 0, cyc = 0;
  logic [31:0] prev_addr = '0;
  logic        prev_redir = 1'b0;
  bit          done = 1'b0;

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'hA5C3_0F00;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // bench's own restatement of ranking and vector rules
  function automatic int pick(input logic [16:0] b);
    for (int i = 0; i < 17; i++) if (b[i]) return i;
    return -1;
  endfunction

  function automatic int bvec(input int s, input int tn, input int lv, input int uv);
    case (s)
      0: return 2;   1: return 3;   2: return 4;   3: return 8;
      4: return 10;  5: return 11;  6: return 61;  7: return 5;
      8: return 14;  9: return 32 + tn;  10: return 9;
      11: return 13; 12: return 12; 13: return 15; 14: return 24;
      15: return (lv == 0) ? 14 : 24 + lv;
      16: return (uv < 64) ? 14 : uv;
      default: return -1;
    endcase
  endfunction

  function automatic bit uses_fault(input int v);
    return (v == 2 || v == 3 || v == 4 || v == 5 || v == 8 ||
            v == 10 || v == 11 || v == 14 || v == 61);
  endfunction

  // memory responder and monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else begin
      exp_t e;
      mem_ack = 1'b0;
      if (mem_req) begin
        if (wcnt > 0) chk(mem_addr == prev_addr, "R6 addr held", mem_addr, prev_addr);
        prev_addr = mem_addr;
        if (wcnt >= wait_cfg) begin
          wcnt = 0;
          mem_ack = 1'b1;
          mem_rdata = memfn(mem_addr);
          if (sbq.size() == 0) chk(1'b0, "R6 unexpected request", mem_addr, 32'h0);
          else begin
            e = sbq.pop_front();
            chk(e.kind == (mem_we ? 0 : 1), {e.tag, " kind"}, 32'(mem_we), 32'(e.kind == 0));
            chk(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
            if (e.kind == 0) chk(mem_wdata == e.data, {e.tag, " data"}, mem_wdata, e.data);
          end
        end else wcnt++;
      end else wcnt = 0;
      if (redirect_valid) begin
        chk(!prev_redir, "R7 single-cycle strobe", 32'(prev_redir), 32'h0);
        if (sbq.size() == 0) chk(1'b0, "R7 unexpected redirect", redirect_pc, 32'h0);
        else begin
          e = sbq.pop_front();
          chk(e.kind == 2, "R7 redirect order", 32'(e.kind), 32'd2);
          chk(redirect_pc == e.addr, {e.tag, " handler"}, redirect_pc, e.addr);
          chk(redirect_sp == e.data, "R7 new sp", redirect_sp, e.data);
        end
      end
      prev_redir = redirect_valid;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  task automatic fire(input logic [16:0] bits, input int tn, input int lv, input int uv,
                      input logic [31:0] fpc, input logic [31:0] npc,
                      input logic [15:0] srv, input logic [31:0] spv,
                      input bit do_retire, input string tag);
    int v;
    logic [31:0] spc, taddr;
    v = bvec(pick(bits), tn, lv, uv);
    spc = uses_fault(v) ? fpc : npc;
    taddr = tbl_base + 32'(v * 4);
    sbq.push_back('{0, spv - 32'd4, spc, {tag, " R4 R5 saved pc"}});
    sbq.push_back('{0, spv - 32'd8, {6'b010000, 8'(v), 2'b00, srv}, {tag, " R5 fv word"}});
    sbq.push_back('{1, taddr, 32'h0, {tag, " R7 table read"}});
    sbq.push_back('{2, memfn(taddr), spv - 32'd8, {tag, " R7"}});
    @(negedge clk);
    trap_num = 4'(tn); irq_level = 3'(lv); irq_vec = 8'(uv);
    fault_pc = fpc; next_pc = npc; sr = srv; sp = spv;
    exc_req = bits;
    do @(negedge clk); while (!mem_req);
    exc_req = '0;
    while (sbq.size() != 0) @(negedge clk);
    if (do_retire) begin
      first_retired = 1'b1;
      @(negedge clk);
      first_retired = 1'b0;
      chk(!irq_inhibit, "R8 released after retire", 32'(irq_inhibit), 32'h0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req, "R10 no request in reset", 32'(mem_req), 32'h0);
    chk(!redirect_valid, "R10 no redirect in reset", 32'(redirect_valid), 32'h0);
    chk(!irq_inhibit, "R10 inhibit low in reset", 32'(irq_inhibit), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !irq_inhibit, "R10 idle after reset", 32'(mem_req), 32'h0);

    fire(17'h00001, 0, 0, 0, 32'h100, 32'h104, 16'h2700, 32'h8000, 1, "R2 access");
    fire(17'h00400, 0, 0, 0, 32'h200, 32'h206, 16'h2000, 32'h7F00, 1, "R2 R4 trace");
    fire(17'h00200, 5, 0, 0, 32'h300, 32'h302, 16'h2100, 32'h7E00, 1, "R2 trap5");
    wait_cfg = 3;
    fire(17'h08000, 0, 3, 0, 32'h400, 32'h404, 16'h2300, 32'h7D00, 1, "R2 R6 autovec3");
    fire(17'h10000, 0, 0, 8'h80, 32'h500, 32'h504, 16'h2000, 32'h7C00, 1, "R2 user80");
    fire(17'h10000, 0, 0, 8'h20, 32'h600, 32'h604, 16'h2000, 32'h7B00, 1, "R3 low user vec");
    wait_cfg = 1;
    fire(17'h08000, 0, 0, 0, 32'h700, 32'h704, 16'h2000, 32'h7A00, 1, "R3 level0");
    fire(17'h08005, 0, 2, 0, 32'h800, 32'h804, 16'h2000, 32'h7900, 1, "R1 access wins");
    fire(17'h00404, 0, 0, 0, 32'h900, 32'h904, 16'h2000, 32'h7800, 1, "R1 illegal over trace");
    fire(17'h10400, 0, 0, 8'h90, 32'hA00, 32'hA04, 16'h2000, 32'h7700, 1, "R1 trace over irq");
    wait_cfg = 0;
    fire(17'h00280, 7, 0, 0, 32'hB00, 32'hB02, 16'h2000, 32'h7600, 1, "R1 divz over trap");
    fire(17'h00040, 0, 0, 0, 32'hC00, 32'hC04, 16'h2000, 32'h7500, 1, "R2 R4 unsupported");
    fire(17'h01000, 0, 0, 0, 32'hD00, 32'hD04, 16'h2000, 32'h7400, 1, "R2 nonpc bkpt");
    fire(17'h00800, 0, 0, 0, 32'hE00, 32'hE04, 16'h2000, 32'h7300, 1, "R2 pc bkpt");

    // hold window: interrupts and trace ignored, a fault nests
    fire(17'h00100, 0, 0, 0, 32'hF00, 32'hF04, 16'h2700, 32'h7200, 0, "R2 format");
    chk(irq_inhibit, "R8 inhibit after redirect", 32'(irq_inhibit), 32'h1);
    @(negedge clk);
    irq_level = 3'd5;
    irq_vec = 8'hC0;
    exc_req = 17'h18400;
    repeat (4) @(negedge clk);
    chk(!mem_req, "R8 irq ignored in hold", 32'(mem_req), 32'h0);
    chk(irq_inhibit, "R8 inhibit held", 32'(irq_inhibit), 32'h1);
    exc_req = '0;
    fire(17'h00004, 0, 0, 0, 32'h1000, 32'h1002, 16'h2700, 32'h71F8, 1, "R9 nested illegal");

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R7 scoreboard drained", 32'(sbq.size()), 32'h0);
    finish_run();
  end

endmodule